// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This block narrows an integer by dropping a selectable number of low-order bits. Before the bits are dropped, it applies one of four fixed-point rounding rules. The operand can be treated as two's-complement or as unsigned. A signed operand is shifted arithmetically, so its sign is kept. An unsigned operand is shifted logically. The result has the same width as the operand and holds the rounded quotient of the operand divided by two to the power of the shift amount.

The block is meant to sit at the end of a fixed-point multiply or accumulate path, where a wide intermediate is scaled back down. Each operation is presented with a valid strobe. The result appears with its own valid strobe one clock later, from an output register that a parameter can remove. Any shift amount from zero up to one less than the operand width is accepted.

Top module: `fxp_round_shift`

## Requirements
- R1: Mode code 0 (nearest, ties up) returns floor(x / 2^s) plus the discarded bit at position s-1.
- R2: Mode code 1 (nearest, ties to even) adds one to floor(x / 2^s) only when bit s-1 is 1 and, in addition, either some bit below s-1 is 1 or bit s of the operand is 1.
- R3: In mode code 1, a discarded remainder strictly above one half rounds up even when the kept LSB (bit s) is 0.
- R4: In mode code 1, an exact half stays put when bit s is 0 and rounds up when bit s is 1.
- R5: Mode code 2 (round down) returns floor(x / 2^s) with no adjustment.
- R6: Mode code 3 (round to odd) sets bit 0 of the result only when at least one discarded bit is nonzero. Otherwise it returns floor(x / 2^s) unchanged.
- R7: With s = 0, every mode returns the operand unchanged. Round to odd does not set bit 0 in this case.
- R8: Shift amounts up to DATA_W-1 are supported, and a round-up of an all-ones operand does not wrap. For example, 0xFFFF unsigned with s = 1 in mode 0 gives 0x8000.
- R9: With in_signed = 1 the shift extends the sign bit. With in_signed = 0 it fills with zeros.
- R10: out_valid follows in_valid one clock later, and out_data holds the result of that operation. A reset clears out_valid and out_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_signed | input | 1 | 1: two's-complement operand, 0: unsigned |
| in_data | input | DATA_W | Operand |
| in_shamt | input | SHAMT_W | Number of low bits to discard (0 to DATA_W-1) |
| in_mode | input | 2 | Rounding rule: 0 nearest-up, 1 nearest-even, 2 down, 3 odd |
| out_valid | output | 1 | Result strobe |
| out_data | output | DATA_W | Rounded, shifted result |

## Verification
The bench builds the block with DATA_W = 16, which gives a four-bit shift amount, and keeps the output register (REG_OUT = 1). At this width the full 0 to 15 shift range is reachable. Random operands therefore reach both the zero-shift edge and the shift of 15, where only the sign bit survives and the guard bit sits at bit 14. With 16-bit operands, exact-half ties, the all-ones carry case and negative values near the sign boundary can all be written as short directed vectors. The expected values come from a division-and-remainder model, not from bit taps.

// File: rtl/fxp_rnd_pkg.sv
// Package: shared types for the rounding right shifter.
// Assumes nothing beyond a 2-bit mode select.
package fxp_rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'd0,
        RM_NEAR_EVEN = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ODD       = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/fxp_rnd_taps.sv
// Module: fxp_rnd_taps
// Extracts the bits that every rounding rule looks at: the guard bit just
// below the cut, the sticky OR of the bits under the guard, the kept LSB,
// and the OR of all discarded bits.
// Assumes shamt is below DATA_W, so the kept LSB index is always valid.
module fxp_rnd_taps #(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  operand,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               guard,
    output logic               sticky,
    output logic               keep_lsb,
    output logic               any_lost
);
    logic [DATA_W-1:0] below_cut;
    logic [DATA_W-1:0] below_guard;
    logic [DATA_W-1:0] at_guard;

    // One position mask per bit, built from the shift amount.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign below_cut[i]   = (i < int'(shamt));
        assign below_guard[i] = (i + 1 < int'(shamt));
        assign at_guard[i]    = (i + 1 == int'(shamt));
    end

    // Reduce the masked operand into the four rounding inputs.
    always_comb begin
        guard    = |(operand & at_guard);
        sticky   = |(operand & below_guard);
        any_lost = |(operand & below_cut);
        keep_lsb = operand[shamt];
    end
endmodule

// File: rtl/fxp_rnd_decide.sv
// Module: fxp_rnd_decide
// Turns the selected rule and the discarded-bit taps into two controls:
// add one to the shifted value, or force its bit 0 high.
// Assumes the taps come from fxp_rnd_taps for the same operand.
module fxp_rnd_decide
    import fxp_rnd_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      guard,
    input  logic      sticky,
    input  logic      keep_lsb,
    input  logic      any_lost,
    output logic      inc,
    output logic      set_odd
);
    // Per-rule choice of increment or jamming.
    always_comb begin
        inc     = 1'b0;
        set_odd = 1'b0;
        unique case (mode)
            RM_NEAR_UP:   inc = guard;
            RM_NEAR_EVEN: inc = guard & (sticky | keep_lsb);
            RM_DOWN:      inc = 1'b0;
            RM_ODD:       set_odd = any_lost;
            default:      inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/fxp_rnd_core.sv
// Module: fxp_rnd_core
// Extends the operand by one bit (sign or zero), shifts it right and applies
// the rounding controls in a DATA_W+1 wide adder, so that an all-ones round-up
// keeps its carry.
// Assumes inc and set_odd are never both high.
module fxp_rnd_core #(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  operand,
    input  logic               is_signed,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               inc,
    input  logic               set_odd,
    output logic [DATA_W-1:0]  result
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]        ext;
    logic signed [EXT_W-1:0] shifted;
    logic [EXT_W-1:0]        sum;

    // Extend, shift, increment, then jam bit 0 when rounding to odd.
    always_comb begin
        ext     = {is_signed & operand[DATA_W-1], operand};
        shifted = $signed(ext) >>> shamt;
        sum     = shifted + {{DATA_W{1'b0}}, inc};
        sum[0]  = sum[0] | set_odd;
        result  = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/fxp_round_shift.sv
// Module: fxp_round_shift (top)
// A rounding right shifter with a valid strobe. When REG_OUT is 1, results
// are registered and appear one clock after in_valid. When REG_OUT is 0 the
// path is combinational.
// Assumes in_shamt < DATA_W. Reset is synchronous and active low.
module fxp_round_shift
    import fxp_rnd_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_OUT = 1,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_signed,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [SHAMT_W-1:0] in_shamt,
    input  logic [1:0]         in_mode,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);
    logic      guard, sticky, keep_lsb, any_lost;
    logic      inc, set_odd;
    logic [DATA_W-1:0] comb_res;
    rnd_mode_e mode;

    assign mode = rnd_mode_e'(in_mode);

    fxp_rnd_taps #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_taps (
        .operand (in_data),
        .shamt   (in_shamt),
        .guard   (guard),
        .sticky  (sticky),
        .keep_lsb(keep_lsb),
        .any_lost(any_lost)
    );

    fxp_rnd_decide u_decide (
        .mode    (mode),
        .guard   (guard),
        .sticky  (sticky),
        .keep_lsb(keep_lsb),
        .any_lost(any_lost),
        .inc     (inc),
        .set_odd (set_odd)
    );

    fxp_rnd_core #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_core (
        .operand  (in_data),
        .is_signed(in_signed),
        .shamt    (in_shamt),
        .inc      (inc),
        .set_odd  (set_odd),
        .result   (comb_res)
    );

    if (REG_OUT != 0) begin : g_reg
        // Output register: capture the result and its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_data <= comb_res;
            end
        end

        // R10
        valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R10
        idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R7
        zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_shamt == '0) |=> (out_data == $past(in_data)));
        // R6
        odd_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == RM_ODD && any_lost) |=> out_data[0]);
    end else begin : g_comb
        // Combinational path: the result follows the inputs directly.
        always_comb begin
            out_valid = in_valid;
            out_data  = comb_res;
        end
    end

    // R5
    down_noadj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_DOWN) |-> (!inc && !set_odd));
    // R4
    tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_NEAR_EVEN && guard && !sticky && !keep_lsb) |-> !inc);
    // R3
    above_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_NEAR_EVEN && guard && sticky) |-> inc);
endmodule

// File: tb/sim_fxp_round_shift.sv
module sim_fxp_round_shift;
    localparam int W  = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_signed = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic [SW-1:0] in_shamt = '0;
    logic [1:0]    in_mode = '0;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;
    item_t sbq[$];

    always #10 clk = ~clk;

    fxp_round_shift #(.DATA_W(W), .REG_OUT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_signed(in_signed),
        .in_data(in_data), .in_shamt(in_shamt), .in_mode(in_mode),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Reference: quotient and remainder arithmetic on a 64-bit integer.
    function automatic logic [W-1:0] ref_model(logic [W-1:0] x, bit sgn, int s, int m);
        longint v, q, r, half;
        v    = sgn ? longint'($signed(x)) : longint'(x);
        q    = v >>> s;
        r    = v - (q <<< s);
        half = (s > 0) ? (longint'(1) <<< (s - 1)) : 0;
        case (m)
            0: if (s > 0) q = (v + half) >>> s;
            1: if (s > 0 && (r > half || (r == half && q[0]))) q = q + 1;
            3: if (r != 0) q = q | 1;
            default: ;
        endcase
        return q[W-1:0];
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one operation and queue its expected result.
    task automatic drive(logic [W-1:0] x, bit sgn, int s, int m, string tag);
        item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = x;
        in_signed = sgn;
        in_shamt  = SW'(s);
        in_mode   = 2'(m);
        it.exp = ref_model(x, sgn, s, m);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare each result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10: got out_valid=1 expected 0 (nothing queued)");
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, out_data, it.exp);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {15'd0, out_valid}, 16'd0);
        check("R10", out_data, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(16'h0005, 0, 1, 0, "R1");  // 2.5 -> 3
        drive(16'h0005, 0, 1, 2, "R5");  // 2.5 -> 2
        drive(16'h0005, 0, 1, 1, "R4");  // tie, even kept -> 2
        drive(16'h0007, 0, 1, 1, "R4");  // tie, odd kept -> 4
        drive(16'h000B, 0, 2, 1, "R3");  // 2.75 -> 3
        drive(16'h0009, 0, 2, 1, "R2");  // 2.25 -> 2
        drive(16'h0008, 0, 2, 3, "R6");  // exact -> 2
        drive(16'h0009, 0, 2, 3, "R6");  // inexact -> 3
        for (int m = 0; m < 4; m++) drive(16'h1234, 0, 0, m, "R7");
        drive(16'h0001, 0, 0, 3, "R7");
        drive(16'hFFFF, 0, 1, 0, "R8");  // -> 0x8000
        drive(16'hFFFF, 0, 15, 0, "R8"); // -> 2
        drive(16'h8000, 1, 15, 2, "R8"); // -> 0xFFFF
        drive(16'h7FFF, 1, 1, 0, "R8");  // -> 0x4000
        drive(16'hFFF0, 1, 4, 2, "R9");  // -> 0xFFFF
        drive(16'hFFF0, 0, 4, 2, "R9");  // -> 0x0FFF
        drive(16'hFFFB, 1, 1, 0, "R9");  // -5/2 -> -2
        drive(16'hFFFB, 1, 1, 1, "R9");  // -2.5 tie -> -2
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R10: strobe drops when idle
        check("R10", {15'd0, out_valid}, 16'd0);

        for (int k = 0; k < 600; k++) begin
            int m;
            m = $urandom_range(0, 3);
            drive(16'($urandom), 1'($urandom), $urandom_range(0, 15), m,
                  (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R5" : "R6");
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R10: got %0d pending expected 0", sbq.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule